// File: doc/BRIEF.md
# Result Tag Forwarding Control

This block is the operand-bypass controller of a seven-stage in-order integer pipeline (I1, I2, DE, EX, D1, D2, DW). It keeps a record of every instruction between decode and write-back. Each stage holds a valid bit, and from EX onward each stage also holds a 5-bit destination tag, a writes-result bit and a 2-bit instruction class. From that record it tells the datapath which of five values to feed to each source operand of the instruction now in decode. The five values are the register-file read, the three tagged result registers behind EX, D1 and D2, and the load data register filled in DW. It always selects the youngest producer that is still valid.

A taken branch is detected while the branch sits in EX. The younger instructions are invalidated one clock later, once they have moved down one stage. The block raises a datapath flush strobe when the instruction that has just entered EX must be discarded. The same record also drives the register-file write enable and address and the load-data latch strobe for the DW stage. A global stall input freezes all of this state.

Top module: `fwd_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, `flush_dp`, `rf_we` and `din_load` are 0, and both selects point at the register file.
- R2: `sel_a` and `sel_b` always have exactly one bit set. The bit positions are: bit 0 = EX result, bit 1 = D1 result, bit 2 = D2 result, bit 3 = load data register, bit 4 = register file.
- R3: A pipeline source matches an operand only when its stage is valid, its writes-result bit is 1 and its tag equals the operand address. When more than one source matches, the youngest wins, in the order EX, D1, D2, load data.
- R4: Class codes are LOAD=0, STORE=1, ALU=2, BRANCH=3. A LOAD in EX, D1 or D2 never matches. The load data source matches only a valid LOAD with writes-result set in DW.
- R5: An instruction that is valid in DE with writes-result set drives `rf_we`=1, with `rf_waddr` equal to its tag, four unstalled cycles later. A valid instruction with writes-result clear gives `rf_we`=0.
- R6: `din_load` is 1 exactly when DW holds a valid LOAD.
- R7: A valid BRANCH in EX with `br_taken`=1 and destination bit 0 = 1 (squash form) invalidates the instructions in I1, I2 and DE. This takes effect on the following cycle, in which `flush_dp`=1, and those instructions never forward and never write.
- R8: With destination bit 0 = 0 (execute form), the instruction that was in DE survives and may forward and write. Only the two younger instructions are invalidated, and `flush_dp` stays 0.
- R9: While `stall`=1 no stage advances: the DW outputs hold their values, and a producer in EX keeps forwarding until the stall ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freezes every stage register |
| fetch_valid | input | 1 | A valid instruction enters I1 |
| de_rd | input | 5 | Destination tag of the decode instruction |
| de_wr | input | 1 | Decode instruction writes a result |
| de_type | input | 2 | Class of the decode instruction |
| de_rs1 | input | 5 | First source address in decode |
| de_rs2 | input | 5 | Second source address in decode |
| br_taken | input | 1 | Branch condition result for the EX instruction |
| sel_a | output | 5 | One-hot source select, operand A |
| sel_b | output | 5 | One-hot source select, operand B |
| flush_dp | output | 1 | Discard the datapath EX stage |
| rf_we | output | 1 | Register-file write enable in DW |
| rf_waddr | output | 5 | Register-file write address |
| din_load | output | 1 | Latch the load data register in DW |

## Verification
The selects are combinational: they follow the decode fields and stage record of the same cycle. `flush_dp` is due exactly one edge after the cycle in which the taken branch was seen in EX. `rf_we` and `rf_waddr` for a decode instruction are due after four unstalled edges, and each stalled edge pushes them back by one. The bench drives inputs 1 ns after a rising edge and samples 2 ns later, before the next edge. Every expected write-back and flush is placed at the cycle index reached by counting those edges from the cycle the instruction sat in decode.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int TAG_W      = 5;
    localparam int N_SRC      = 4;
    localparam int SEL_W      = N_SRC + 1;
    localparam int SQUASH_BIT = 0;

    localparam int SRC_EX  = 0;
    localparam int SRC_D1  = 1;
    localparam int SRC_D2  = 2;
    localparam int SRC_DIN = 3;

    typedef enum logic [1:0] {
        IT_LOAD   = 2'd0,
        IT_STORE  = 2'd1,
        IT_ALU    = 2'd2,
        IT_BRANCH = 2'd3
    } itype_e;

    typedef struct packed {
        logic             v;
        logic [TAG_W-1:0] rd;
        logic             wr;
        itype_e           ty;
    } slot_t;

    typedef struct packed {
        logic  i1;
        logic  i2;
        logic  de;
        slot_t ex;
        slot_t d1;
        slot_t d2;
        slot_t dw;
        logic  fl;
        logic  sq;
    } pipe_t;
endpackage

// File: rtl/fwd_pipe.sv
module fwd_pipe
    import fwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic             fetch_valid,
    input  logic [TAG_W-1:0] de_rd,
    input  logic             de_wr,
    input  logic [1:0]       de_type,
    input  logic             br_taken,
    output slot_t            ex_o,
    output slot_t            d1_o,
    output slot_t            d2_o,
    output slot_t            dw_o,
    output logic             flush_dp
);
    pipe_t q, d;
    logic  i2_live, de_live, ex_live;

    // The flush registered last cycle masks the stages the victims now occupy
    always_comb begin
        i2_live = q.i2 & ~q.fl;
        de_live = q.de & ~q.fl;
        ex_live = q.ex.v & ~(q.fl & q.sq);
        d = q;
        if (!stall) begin
            d.i1    = fetch_valid;
            d.i2    = q.i1;
            d.de    = i2_live;
            d.ex.v  = de_live;
            d.ex.rd = de_rd;
            d.ex.wr = de_wr;
            d.ex.ty = itype_e'(de_type);
            d.d1    = q.ex;
            d.d1.v  = ex_live;
            d.d2    = q.d1;
            d.dw    = q.d2;
            d.fl    = ex_live && (q.ex.ty == IT_BRANCH) && br_taken;
            d.sq    = q.ex.rd[SQUASH_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        ex_o     = q.ex;
        ex_o.v   = ex_live;
        d1_o     = q.d1;
        d2_o     = q.d2;
        dw_o     = q.dw;
        flush_dp = q.fl & q.sq;
    end
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick #(
    parameter int N = 4,
    parameter int W = 5
) (
    input  logic [W-1:0]        rs,
    input  logic [N-1:0]        live,
    input  logic [N-1:0][W-1:0] tags,
    output logic [N:0]          sel
);
    logic [N-1:0] hit;
    logic         found;

    for (genvar k = 0; k < N; k++) begin : g_cmp
        assign hit[k] = live[k] && (tags[k] == rs);
    end

    // Index 0 is the youngest source, so the first hit wins
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (hit[k] && !found) begin
                sel[k] = 1'b1;
                found  = 1'b1;
            end
        end
        sel[N] = !found;
    end
endmodule

// File: rtl/fwd_ctrl.sv
module fwd_ctrl
    import fwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic             fetch_valid,
    input  logic [TAG_W-1:0] de_rd,
    input  logic             de_wr,
    input  logic [1:0]       de_type,
    input  logic [TAG_W-1:0] de_rs1,
    input  logic [TAG_W-1:0] de_rs2,
    input  logic             br_taken,
    output logic [SEL_W-1:0] sel_a,
    output logic [SEL_W-1:0] sel_b,
    output logic             flush_dp,
    output logic             rf_we,
    output logic [TAG_W-1:0] rf_waddr,
    output logic             din_load
);
    localparam int N_OPS = 2;

    slot_t                         ex_s, d1_s, d2_s, dw_s;
    logic [N_SRC-1:0]              live;
    logic [N_SRC-1:0][TAG_W-1:0]   tags;
    logic [N_OPS-1:0][TAG_W-1:0]   rs_arr;
    logic [N_OPS-1:0][SEL_W-1:0]   sel_arr;
    logic [TAG_W-1:0]              ex_rd_w;

    fwd_pipe u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall       (stall),
        .fetch_valid (fetch_valid),
        .de_rd       (de_rd),
        .de_wr       (de_wr),
        .de_type     (de_type),
        .br_taken    (br_taken),
        .ex_o        (ex_s),
        .d1_o        (d1_s),
        .d2_o        (d2_s),
        .dw_o        (dw_s),
        .flush_dp    (flush_dp)
    );

    // Result registers behind EX/D1/D2 hold no load data; that arrives in DW
    always_comb begin
        live[SRC_EX]  = ex_s.v && ex_s.wr && (ex_s.ty != IT_LOAD);
        live[SRC_D1]  = d1_s.v && d1_s.wr && (d1_s.ty != IT_LOAD);
        live[SRC_D2]  = d2_s.v && d2_s.wr && (d2_s.ty != IT_LOAD);
        live[SRC_DIN] = dw_s.v && dw_s.wr && (dw_s.ty == IT_LOAD);
        tags[SRC_EX]  = ex_s.rd;
        tags[SRC_D1]  = d1_s.rd;
        tags[SRC_D2]  = d2_s.rd;
        tags[SRC_DIN] = dw_s.rd;
    end

    assign rs_arr[0] = de_rs1;
    assign rs_arr[1] = de_rs2;

    for (genvar op = 0; op < N_OPS; op++) begin : g_op
        fwd_pick #(
            .N (N_SRC),
            .W (TAG_W)
        ) u_pick (
            .rs   (rs_arr[op]),
            .live (live),
            .tags (tags),
            .sel  (sel_arr[op])
        );
    end

    assign sel_a    = sel_arr[0];
    assign sel_b    = sel_arr[1];
    assign rf_we    = dw_s.v && dw_s.wr;
    assign rf_waddr = dw_s.rd;
    assign din_load = dw_s.v && (dw_s.ty == IT_LOAD);
    assign ex_rd_w  = ex_s.rd;
endmodule

// File: rtl/fwd_ctrl_chk.sv
module fwd_ctrl_chk
    import fwd_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             stall,
    input logic             br_taken,
    input logic [TAG_W-1:0] de_rs1,
    input logic [TAG_W-1:0] ex_rd,
    input logic [SEL_W-1:0] sel_a,
    input logic [SEL_W-1:0] sel_b,
    input logic             flush_dp,
    input logic             rf_we,
    input logic [TAG_W-1:0] rf_waddr,
    input logic             din_load
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!flush_dp && !rf_we && !din_load));

    assert_sel_a_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_a) == 1);

    assert_sel_b_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel_b) == 1);

    assert_ex_tag_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_a[0] |-> (de_rs1 == ex_rd));

    assert_flush_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_dp) |-> $past(br_taken));

    assert_flush_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_dp && !stall) |=> !flush_dp);

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(rf_we) && $stable(rf_waddr) && $stable(din_load)));
endmodule

bind fwd_ctrl fwd_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stall    (stall),
    .br_taken (br_taken),
    .de_rs1   (de_rs1),
    .ex_rd    (ex_rd_w),
    .sel_a    (sel_a),
    .sel_b    (sel_b),
    .flush_dp (flush_dp),
    .rf_we    (rf_we),
    .rf_waddr (rf_waddr),
    .din_load (din_load)
);

// File: tb/tb_fwd_ctrl.sv
module tb_fwd_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stall = 1'b0, fetch_valid = 1'b0, de_wr = 1'b0, br_taken = 1'b0;
    logic [4:0] de_rd = '0, de_rs1 = '0, de_rs2 = '0;
    logic [1:0] de_type = '0;
    logic [4:0] sel_a, sel_b, rf_waddr;
    logic       flush_dp, rf_we, din_load;
    int         checks = 0, fails = 0;

    localparam logic [4:0] S_EX = 5'b00001, S_D1 = 5'b00010, S_D2 = 5'b00100,
                           S_DI = 5'b01000, S_RF = 5'b10000;
    localparam logic [1:0] T_L = 2'd0, T_S = 2'd1, T_A = 2'd2, T_B = 2'd3;

    typedef struct packed {
        logic fv; logic [4:0] rd; logic wr; logic [1:0] ty;
        logic [4:0] rs1; logic [4:0] rs2; logic br;
        logic [4:0] ea; logic [4:0] eb; logic ef; logic ew; logic [4:0] eaddr; logic ed;
    } vec_t;

    // Rows 0-2 fill I1/I2; instruction in DE at row r writes back at row r+4
    localparam vec_t TBL [12] = '{
        '{1'b1, 5'd0, 1'b0, T_A, 5'd0, 5'd0, 1'b0, S_RF, S_RF, 1'b0, 1'b0, 5'd0, 1'b0},
        '{1'b1, 5'd0, 1'b0, T_A, 5'd0, 5'd0, 1'b0, S_RF, S_RF, 1'b0, 1'b0, 5'd0, 1'b0},
        '{1'b1, 5'd0, 1'b0, T_A, 5'd0, 5'd0, 1'b0, S_RF, S_RF, 1'b0, 1'b0, 5'd0, 1'b0},
        '{1'b1, 5'd1, 1'b1, T_A, 5'd7, 5'd8, 1'b0, S_RF, S_RF, 1'b0, 1'b0, 5'd0, 1'b0},
        '{1'b1, 5'd2, 1'b1, T_A, 5'd1, 5'd3, 1'b0, S_EX, S_RF, 1'b0, 1'b0, 5'd0, 1'b0},
        '{1'b1, 5'd3, 1'b1, T_L, 5'd2, 5'd1, 1'b0, S_EX, S_D1, 1'b0, 1'b0, 5'd0, 1'b0},
        '{1'b1, 5'd1, 1'b1, T_A, 5'd1, 5'd3, 1'b0, S_D2, S_RF, 1'b0, 1'b0, 5'd0, 1'b0}, // R4 load in EX skipped
        '{1'b1, 5'd4, 1'b0, T_S, 5'd1, 5'd2, 1'b0, S_EX, S_D2, 1'b0, 1'b1, 5'd1, 1'b0}, // R5 first write
        '{1'b1, 5'd5, 1'b1, T_A, 5'd3, 5'd4, 1'b0, S_RF, S_RF, 1'b0, 1'b1, 5'd2, 1'b0}, // R3 wr=0 ignored
        '{1'b1, 5'd6, 1'b1, T_A, 5'd3, 5'd1, 1'b0, S_DI, S_D2, 1'b0, 1'b1, 5'd3, 1'b1}, // R4 R6 load data
        '{1'b1, 5'd5, 1'b1, T_A, 5'd5, 5'd6, 1'b0, S_D1, S_EX, 1'b0, 1'b1, 5'd1, 1'b0},
        '{1'b1, 5'd0, 1'b0, T_A, 5'd5, 5'd1, 1'b0, S_EX, S_RF, 1'b0, 1'b0, 5'd0, 1'b0}  // R3 EX beats D2
    };

    fwd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .stall(stall), .fetch_valid(fetch_valid),
        .de_rd(de_rd), .de_wr(de_wr), .de_type(de_type), .de_rs1(de_rs1),
        .de_rs2(de_rs2), .br_taken(br_taken), .sel_a(sel_a), .sel_b(sel_b),
        .flush_dp(flush_dp), .rf_we(rf_we), .rf_waddr(rf_waddr), .din_load(din_load)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic fv, input logic [4:0] rd, input logic wr,
                       input logic [1:0] ty, input logic [4:0] rs1,
                       input logic [4:0] rs2, input logic br, input logic st);
        @(posedge clk);
        #1;
        fetch_valid = fv; de_rd = rd; de_wr = wr; de_type = ty;
        de_rs1 = rs1; de_rs2 = rs2; br_taken = br; stall = st;
        #2;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fetch_valid = 1'b0; de_rd = '0; de_wr = 1'b0; de_type = '0;
        de_rs1 = 5'd5; de_rs2 = 5'd6; br_taken = 1'b0; stall = 1'b0;
        #1;
        chk("R1 sel_a in reset", int'(sel_a), int'(S_RF));
        chk("R1 sel_b in reset", int'(sel_b), int'(S_RF));
        chk("R1 strobes in reset", int'({flush_dp, rf_we, din_load}), 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic warm();
        for (int i = 0; i < 3; i++) cyc(1'b1, 5'd0, 1'b0, T_A, 5'd0, 5'd0, 1'b0, 1'b0);
    endtask

    task automatic chk_wb(input string tag, input logic we, input logic [4:0] addr);
        chk(tag, int'(rf_we), int'(we));
        if (we) chk(tag, int'(rf_waddr), int'(addr));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        cyc(1'b1, 5'd0, 1'b0, T_A, 5'd0, 5'd0, 1'b0, 1'b0);
        chk("R1 first cycle strobes", int'({flush_dp, rf_we, din_load}), 0);

        // Table walk: R2 encoding, R3 priority, R4 load rules, R5/R6 write-back
        for (int i = 1; i < 12; i++) begin
            cyc(TBL[i].fv, TBL[i].rd, TBL[i].wr, TBL[i].ty, TBL[i].rs1, TBL[i].rs2, TBL[i].br, 1'b0);
            chk($sformatf("R2/R3 sel_a row %0d", i), int'(sel_a), int'(TBL[i].ea));
            chk($sformatf("R2/R4 sel_b row %0d", i), int'(sel_b), int'(TBL[i].eb));
            chk($sformatf("R5/R6 strobes row %0d", i),
                int'({TBL[i].ef, rf_we, din_load}), int'({TBL[i].ef, TBL[i].ew, TBL[i].ed}));
            if (TBL[i].ew) chk($sformatf("R5 waddr row %0d", i), int'(rf_waddr), int'(TBL[i].eaddr));
        end

        // Mid-run reset with a full pipeline (R1)
        do_reset();

        // Squash branch (R7)
        warm();
        cyc(1'b1, 5'd9,  1'b1, T_A, 5'd0,  5'd0, 1'b0, 1'b0);
        cyc(1'b1, 5'd1,  1'b0, T_B, 5'd0,  5'd0, 1'b0, 1'b0);
        cyc(1'b1, 5'd10, 1'b1, T_A, 5'd0,  5'd0, 1'b1, 1'b0);
        chk("R7 no flush in resolve cycle", int'(flush_dp), 0);
        cyc(1'b1, 5'd11, 1'b1, T_A, 5'd10, 5'd0, 1'b0, 1'b0);
        chk("R7 flush_dp one cycle late", int'(flush_dp), 1);
        chk("R7 flushed EX not forwarded", int'(sel_a), int'(S_RF));
        cyc(1'b1, 5'd12, 1'b1, T_A, 5'd0, 5'd0, 1'b0, 1'b0);
        chk("R7 flush_dp single cycle", int'(flush_dp), 0);
        chk_wb("R7 older write kept", 1'b1, 5'd9);
        cyc(1'b1, 5'd13, 1'b1, T_A, 5'd0, 5'd0, 1'b0, 1'b0);
        cyc(1'b1, 5'd0, 1'b0, T_A, 5'd0, 5'd0, 1'b0, 1'b0);
        chk_wb("R7 squashed DE no write", 1'b0, 5'd0);
        cyc(1'b1, 5'd0, 1'b0, T_A, 5'd0, 5'd0, 1'b0, 1'b0);
        chk_wb("R7 squashed I2 no write", 1'b0, 5'd0);
        cyc(1'b1, 5'd0, 1'b0, T_A, 5'd0, 5'd0, 1'b0, 1'b0);
        chk_wb("R7 squashed I1 no write", 1'b0, 5'd0);
        cyc(1'b1, 5'd0, 1'b0, T_A, 5'd0, 5'd0, 1'b0, 1'b0);
        chk_wb("R7 next fetch writes", 1'b1, 5'd13);

        // Execute-form branch (R8)
        do_reset();
        warm();
        cyc(1'b1, 5'd0,  1'b0, T_B, 5'd0,  5'd0, 1'b0, 1'b0);
        cyc(1'b1, 5'd14, 1'b1, T_A, 5'd0,  5'd0, 1'b1, 1'b0);
        cyc(1'b1, 5'd15, 1'b1, T_A, 5'd14, 5'd0, 1'b0, 1'b0);
        chk("R8 no flush_dp", int'(flush_dp), 0);
        chk("R8 delay slot forwards", int'(sel_a), int'(S_EX));
        cyc(1'b1, 5'd16, 1'b1, T_A, 5'd0, 5'd0, 1'b0, 1'b0);
        cyc(1'b1, 5'd17, 1'b1, T_A, 5'd0, 5'd0, 1'b0, 1'b0);
        cyc(1'b1, 5'd0,  1'b0, T_A, 5'd0, 5'd0, 1'b0, 1'b0);
        chk_wb("R8 delay slot writes", 1'b1, 5'd14);
        cyc(1'b1, 5'd0, 1'b0, T_A, 5'd0, 5'd0, 1'b0, 1'b0);
        chk_wb("R8 flushed DE no write", 1'b0, 5'd0);
        cyc(1'b1, 5'd0, 1'b0, T_A, 5'd0, 5'd0, 1'b0, 1'b0);
        chk_wb("R8 flushed I2 no write", 1'b0, 5'd0);
        cyc(1'b1, 5'd0, 1'b0, T_A, 5'd0, 5'd0, 1'b0, 1'b0);
        chk_wb("R8 later fetch writes", 1'b1, 5'd17);

        // Stall (R9)
        do_reset();
        warm();
        cyc(1'b1, 5'd20, 1'b1, T_A, 5'd0,  5'd0, 1'b0, 1'b0);
        cyc(1'b1, 5'd21, 1'b1, T_A, 5'd0,  5'd0, 1'b0, 1'b1);
        cyc(1'b1, 5'd21, 1'b1, T_A, 5'd20, 5'd0, 1'b0, 1'b1);
        chk("R9 EX held during stall", int'(sel_a), int'(S_EX));
        chk_wb("R9 no write during stall", 1'b0, 5'd0);
        cyc(1'b1, 5'd21, 1'b1, T_A, 5'd0, 5'd0, 1'b0, 1'b0);
        cyc(1'b1, 5'd0,  1'b0, T_A, 5'd0, 5'd0, 1'b0, 1'b0);
        cyc(1'b1, 5'd0,  1'b0, T_A, 5'd0, 5'd0, 1'b0, 1'b0);
        chk_wb("R9 write not yet due", 1'b0, 5'd0);
        cyc(1'b1, 5'd0, 1'b0, T_A, 5'd0, 5'd0, 1'b0, 1'b0);
        chk_wb("R9 write delayed by stall", 1'b1, 5'd20);
        cyc(1'b1, 5'd0, 1'b0, T_A, 5'd0, 5'd0, 1'b0, 1'b0);
        chk_wb("R9 held DE instruction writes", 1'b1, 5'd21);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule